// File: doc/BRIEF.md
# Chained Sprite Position Resolver

This block keeps a list of sprite attributes that a processor fills through a byte-wide write port, and turns that list into absolute screen positions for a renderer. On a start pulse a scanner walks the list from index 0 upward. For each sprite it works out the position and carries it forward as the base for the next entry. Every enabled sprite is handed to the renderer with its index, signed X and Y, and image number over a valid/ready handshake.

Each sprite either places itself at absolute coordinates or treats its coordinate bytes as a signed step from the previous entry's resolved position. A group of sprites can be built as one absolute head followed by relative members. Rewriting only the head's coordinates then moves the whole group. A hidden member still passes its position on, so hiding it does not break the chain. While a scan runs the block reports busy, and processor writes and further start pulses are dropped.

Top module: `sprite_chain_resolver`

## Requirements
- R1: After reset the block is idle (busy, valid and done low) and every sprite is disabled, so a scan emits nothing.
- R2: A write stores cpuData into the table chosen by cpuAddr[10:9] (0 = X low byte, 1 = Y byte, 2 = image number, 3 = control byte), at the sprite index in cpuAddr[8:0].
- R3: In the control byte, bit 0 is bit 8 of X, bit 1 enables the sprite and bit 2 selects relative placement.
- R4: An absolute sprite resolves X to its 9-bit value {bit 0, X byte}, read as two's complement and sign-extended to 12 bits, and resolves Y to its Y byte, zero-extended.
- R5: A relative sprite resolves to the previous entry's resolved position plus its 9-bit X and 8-bit Y values, each read as two's complement and sign-extended. The base is (0,0) before index 0, and results wrap modulo 4096.
- R6: Changing only the coordinates of an absolute chain head shifts every following relative sprite by the same amount.
- R7: A disabled sprite is not emitted, but its resolved position still becomes the base for the next sprite.
- R8: Enabled sprites are emitted once each, in rising index order, one valid/ready transfer per sprite. All outputs hold steady while outValid is high and outReady is low.
- R9: After index 511 has been handled, scanDone is high for exactly one cycle, and busy is already low in that cycle.
- R10: cpuBusy is high from the cycle after an accepted start until the end of the scan. Writes and start pulses that arrive while busy are ignored.
- R11: A write and a start pulse in the same idle cycle are both accepted, and the scan that starts uses the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuWe | input | 1 | Write strobe |
| cpuAddr | input | 11 | Table select and sprite index |
| cpuData | input | 8 | Write data byte |
| cpuBusy | output | 1 | Scan in progress, writes dropped |
| scanStart | input | 1 | Start a scan (accepted when idle) |
| outValid | output | 1 | Resolved sprite available |
| outReady | input | 1 | Renderer accepts the sprite |
| outIndex | output | 9 | Index of the emitted sprite |
| outX | output | 12 | Resolved signed X |
| outY | output | 12 | Resolved signed Y |
| outImage | output | 8 | Image number |
| scanDone | output | 1 | One-cycle end-of-scan pulse |

## Verification
A processor write and the scan's use of the tables can meet in the same cycle, and both orders matter. In one test a write is driven together with the start pulse while the block is idle, and the emitted image number must be the new one. In another a write and a second start pulse arrive several cycles into a scan. That write must leave no trace: the following scan must still resolve the old head position, and the block must go idle after the first scan's done pulse with no second scan behind it.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int CTL_XHI = 0;
  localparam int CTL_EN  = 1;
  localparam int CTL_REL = 2;

  localparam logic [1:0] TAB_XLO = 2'd0;
  localparam logic [1:0] TAB_Y   = 2'd1;
  localparam logic [1:0] TAB_IMG = 2'd2;
  localparam logic [1:0] TAB_CTL = 2'd3;
  localparam int NUM_TABLES = 4;

  typedef struct packed {
    logic clearBase;
    logic loadEntry;
    logic advance;
  } spr_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2
  } spr_state_t;
endpackage

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
#(
  parameter int NUM_SPRITES = 512,
  parameter int ACC_W       = 12,
  localparam int IDX_W      = $clog2(NUM_SPRITES),
  localparam int ADDR_W     = IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuData,
  input  logic                    busy,
  input  spr_strobe_t             strobe,
  output logic                    entryEn,
  output logic                    isLast,
  output logic                    latchedEn,
  output logic [IDX_W-1:0]        outIndex,
  output logic signed [ACC_W-1:0] outX,
  output logic signed [ACC_W-1:0] outY,
  output logic [7:0]              outImage
);
  localparam int XW = 9;
  localparam int YW = 8;

  logic                    wrAccept;
  logic [1:0]              wrSel;
  logic [IDX_W-1:0]        wrIdx;
  logic [IDX_W-1:0]        scanIdx;
  logic [NUM_TABLES-1:0][7:0] rdByte;
  logic signed [ACC_W-1:0] baseX, baseY;
  logic signed [ACC_W-1:0] xExt, yAbs, ySgn, resX, resY;
  logic                    relMode;

  assign wrAccept = cpuWe & ~busy;
  assign wrSel    = cpuAddr[ADDR_W-1 -: 2];
  assign wrIdx    = cpuAddr[IDX_W-1:0];

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tab
    logic [7:0] mem [NUM_SPRITES];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_SPRITES; i++) mem[i] <= '0;
      end else if (wrAccept && wrSel == 2'(t)) begin
        mem[wrIdx] <= cpuData;
      end
    end
    assign rdByte[t] = mem[scanIdx];
  end

  always_comb begin
    xExt    = ACC_W'($signed({rdByte[TAB_CTL][CTL_XHI], rdByte[TAB_XLO]}));
    yAbs    = ACC_W'({1'b0, rdByte[TAB_Y]});
    ySgn    = ACC_W'($signed(rdByte[TAB_Y]));
    relMode = rdByte[TAB_CTL][CTL_REL];
    if (relMode) begin
      resX = baseX + xExt;
      resY = baseY + ySgn;
    end else begin
      resX = xExt;
      resY = yAbs;
    end
  end

  assign entryEn = rdByte[TAB_CTL][CTL_EN];
  assign isLast  = (scanIdx == IDX_W'(NUM_SPRITES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx   <= '0;
      baseX     <= '0;
      baseY     <= '0;
      outX      <= '0;
      outY      <= '0;
      outImage  <= '0;
      outIndex  <= '0;
      latchedEn <= 1'b0;
    end else begin
      if (strobe.clearBase) begin
        scanIdx <= '0;
        baseX   <= '0;
        baseY   <= '0;
      end
      if (strobe.loadEntry) begin
        baseX     <= resX;
        baseY     <= resY;
        outX      <= resX;
        outY      <= resY;
        outImage  <= rdByte[TAB_IMG];
        outIndex  <= scanIdx;
        latchedEn <= entryEn;
      end
      if (strobe.advance) scanIdx <= scanIdx + 1'b1;
    end
  end

  // R8: the control never asks to restart and load in the same cycle
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clearBase && (strobe.loadEntry || strobe.advance)));

  // R10: strobes that walk the list only occur while busy
  assert_walk_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEntry || strobe.advance) |-> busy);

  // R5: a fresh scan begins at index 0 with a zero base
  assert_clear_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearBase |=> (scanIdx == '0) && (baseX == '0) && (baseY == '0));

  localparam int UNUSED_W = XW + YW;
endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        scanStart,
  input  logic        outReady,
  input  logic        entryEn,
  input  logic        isLast,
  input  logic        latchedEn,
  output spr_strobe_t strobe,
  output logic        busy,
  output logic        outValid,
  output logic        scanDone
);
  spr_state_t state, stateNx;
  logic       finish;

  always_comb begin
    stateNx = state;
    strobe  = '0;
    finish  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (scanStart) begin
          strobe.clearBase = 1'b1;
          stateNx          = ST_SCAN;
        end
      end
      ST_SCAN: begin
        strobe.loadEntry = 1'b1;
        if (entryEn) begin
          stateNx = ST_EMIT;
        end else if (isLast) begin
          finish  = 1'b1;
          stateNx = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
        end
      end
      ST_EMIT: begin
        if (outReady) begin
          if (isLast) begin
            finish  = 1'b1;
            stateNx = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            stateNx        = ST_SCAN;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      scanDone <= 1'b0;
    end else begin
      state    <= stateNx;
      scanDone <= finish;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_EMIT);

  // R7: only an enabled entry reaches the output
  assert_emit_enabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> latchedEn);

  // R9: done comes with busy already low, right after a busy cycle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (!busy && $past(busy)));

  // R9: done lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  // R10: valid only inside a scan
  assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);
endmodule

// File: rtl/sprite_chain_resolver.sv
module sprite_chain_resolver
  import spr_pkg::*;
#(
  parameter int NUM_SPRITES = 512,
  parameter int ACC_W       = 12,
  localparam int IDX_W      = $clog2(NUM_SPRITES),
  localparam int ADDR_W     = IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuData,
  output logic                    cpuBusy,
  input  logic                    scanStart,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [IDX_W-1:0]        outIndex,
  output logic signed [ACC_W-1:0] outX,
  output logic signed [ACC_W-1:0] outY,
  output logic [7:0]              outImage,
  output logic                    scanDone
);
  spr_strobe_t strobe;
  logic        entryEn, isLast, latchedEn;

  spr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scanStart (scanStart),
    .outReady  (outReady),
    .entryEn   (entryEn),
    .isLast    (isLast),
    .latchedEn (latchedEn),
    .strobe    (strobe),
    .busy      (cpuBusy),
    .outValid  (outValid),
    .scanDone  (scanDone)
  );

  spr_datapath #(
    .NUM_SPRITES (NUM_SPRITES),
    .ACC_W       (ACC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuWe     (cpuWe),
    .cpuAddr   (cpuAddr),
    .cpuData   (cpuData),
    .busy      (cpuBusy),
    .strobe    (strobe),
    .entryEn   (entryEn),
    .isLast    (isLast),
    .latchedEn (latchedEn),
    .outIndex  (outIndex),
    .outX      (outX),
    .outY      (outY),
    .outImage  (outImage)
  );

  // R8: a stalled transfer keeps every output steady
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outX) && $stable(outY)
                                 && $stable(outImage) && $stable(outIndex)));
endmodule

// File: tb/sim_sprite_chain_resolver.sv
module sim_sprite_chain_resolver;
  localparam int NSPR = 512;
  localparam int MAXG = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuWe = 1'b0;
  logic [10:0]       cpuAddr = '0;
  logic [7:0]        cpuData = '0;
  logic              cpuBusy;
  logic              scanStart = 1'b0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [8:0]        outIndex;
  logic signed [11:0] outX, outY;
  logic [7:0]        outImage;
  logic              scanDone;

  always #2 clk = ~clk;

  sprite_chain_resolver u0 (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuBusy(cpuBusy), .scanStart(scanStart), .outValid(outValid), .outReady(outReady),
    .outIndex(outIndex), .outX(outX), .outY(outY), .outImage(outImage), .scanDone(scanDone)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] shX [NSPR];
  logic [7:0] shY [NSPR];
  logic [7:0] shI [NSPR];
  logic [7:0] shC [NSPR];

  int gotN, expN;
  int gotIdx [MAXG], gotX [MAXG], gotY [MAXG], gotImg [MAXG];
  int expIdx [MAXG], expX [MAXG], expY [MAXG], expImg [MAXG];
  int doneCnt, busyAtDone, holdErr;
  int wrT, wrI, wrD;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap12(input int v);
    int r;
    r = v & 32'hFFF;
    if (r >= 2048) r = r - 4096;
    return r;
  endfunction

  task automatic wr(input int t, input int idx, input int d);
    @(negedge clk);
    cpuWe   = 1'b1;
    cpuAddr = {t[1:0], idx[8:0]};
    cpuData = d[7:0];
    @(negedge clk);
    cpuWe   = 1'b0;
    if (t == 0) shX[idx] = d[7:0];
    if (t == 1) shY[idx] = d[7:0];
    if (t == 2) shI[idx] = d[7:0];
    if (t == 3) shC[idx] = d[7:0];
  endtask

  task automatic setSprite(input int idx, input int x9, input int y, input int img,
                           input bit en, input bit rel);
    wr(0, idx, x9 & 255);
    wr(1, idx, y & 255);
    wr(2, idx, img);
    wr(3, idx, ((x9 >> 8) & 1) | (int'(en) << 1) | (int'(rel) << 2));
  endtask

  // Model of R3, R4, R5, R7 from the shadow tables
  task automatic buildExp();
    int bx, by;
    bx = 0; by = 0; expN = 0;
    for (int i = 0; i < NSPR; i++) begin
      int ax, ay, sy, rx, ry;
      ax = (int'(shC[i][0]) << 8) | int'(shX[i]);
      if (ax >= 256) ax = ax - 512;
      ay = int'(shY[i]);
      sy = (ay >= 128) ? ay - 256 : ay;
      if (shC[i][2]) begin rx = wrap12(bx + ax); ry = wrap12(by + sy); end
      else begin rx = ax; ry = ay; end
      bx = rx; by = ry;
      if (shC[i][1] && expN < MAXG) begin
        expIdx[expN] = i; expX[expN] = rx; expY[expN] = ry; expImg[expN] = int'(shI[i]);
        expN++;
      end
    end
  endtask

  // mode 0 plain, 1 write with start, 2 write and start mid-scan
  task automatic runScan(input bit stall, input int mode, input string req);
    int cyc, px, py, pi, pg;
    bit prevV, prevR, newR, finished;
    @(negedge clk);
    scanStart = 1'b1;
    if (mode == 1) begin
      cpuWe = 1'b1; cpuAddr = {wrT[1:0], wrI[8:0]}; cpuData = wrD[7:0];
    end
    cyc = 0; doneCnt = 0; busyAtDone = 0; holdErr = 0; gotN = 0;
    prevV = 0; prevR = 0; finished = 0; px = 0; py = 0; pi = 0; pg = 0;
    while (!finished && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      scanStart = 1'b0;
      cpuWe     = 1'b0;
      if (mode == 2 && cyc == 5) begin
        chk(cpuBusy == 1'b1, "R10", "busy during scan", int'(cpuBusy), 1);
        cpuWe = 1'b1; cpuAddr = {wrT[1:0], wrI[8:0]}; cpuData = wrD[7:0];
        scanStart = 1'b1;
      end
      if (prevV && !prevR) begin
        if (!outValid || int'(outX) != px || int'(outY) != py ||
            int'(outIndex) != pi || int'(outImage) != pg) holdErr++;
      end
      if (scanDone) begin
        doneCnt++;
        if (cpuBusy) busyAtDone++;
      end
      if (doneCnt > 0 && !scanDone) finished = 1;
      newR = stall ? ((cyc % 3) != 0) : 1'b1;
      outReady = newR;
      if (outValid && newR && gotN < MAXG) begin
        gotIdx[gotN] = int'(outIndex); gotX[gotN] = int'(outX);
        gotY[gotN] = int'(outY); gotImg[gotN] = int'(outImage);
        gotN++;
      end
      prevV = outValid; prevR = newR;
      px = int'(outX); py = int'(outY); pi = int'(outIndex); pg = int'(outImage);
    end
    cpuWe = 1'b0; scanStart = 1'b0;
    chk(doneCnt == 1, "R9", "done pulse length", doneCnt, 1);
    chk(busyAtDone == 0, "R9", "busy while done", busyAtDone, 0);
    chk(holdErr == 0, "R8", "outputs held during stall", holdErr, 0);
    buildExp();
    chk(gotN == expN, req, "emitted count", gotN, expN);
    for (int k = 0; k < gotN && k < expN; k++) begin
      chk(gotIdx[k] == expIdx[k], "R8", "index order", gotIdx[k], expIdx[k]);
      chk(gotX[k] == expX[k], req, "resolved X", gotX[k], expX[k]);
      chk(gotY[k] == expY[k], req, "resolved Y", gotY[k], expY[k]);
      chk(gotImg[k] == expImg[k], "R2", "image number", gotImg[k], expImg[k]);
    end
  endtask

  function automatic int findGot(input int idx);
    for (int k = 0; k < gotN; k++) if (gotIdx[k] == idx) return k;
    return -1;
  endfunction

  task automatic testReset();
    chk(cpuBusy == 0, "R1", "busy after reset", int'(cpuBusy), 0);
    chk(outValid == 0, "R1", "valid after reset", int'(outValid), 0);
    chk(scanDone == 0, "R1", "done after reset", int'(scanDone), 0);
    runScan(1'b0, 0, "R1");
    chk(gotN == 0, "R1", "nothing emitted after reset", gotN, 0);
  endtask

  task automatic testAbsolute();
    int k;
    setSprite(0, -2, 4, 1, 1'b1, 1'b1);
    setSprite(3, 10, 200, 5, 1'b1, 1'b0);
    setSprite(7, -1, 0, 2, 1'b1, 1'b0);
    runScan(1'b1, 0, "R4");
    k = findGot(0);
    chk(k >= 0 && gotX[k] == -2 && gotY[k] == 4, "R5", "relative from zero base X", (k >= 0) ? gotX[k] : -999, -2);
    k = findGot(3);
    chk(k >= 0 && gotY[k] == 200, "R4", "absolute Y zero-extended", (k >= 0) ? gotY[k] : -999, 200);
    k = findGot(7);
    chk(k >= 0 && gotX[k] == -1, "R4", "absolute X negative", (k >= 0) ? gotX[k] : -999, -1);
  endtask

  task automatic testChain();
    int k;
    setSprite(10, 20, 30, 3, 1'b1, 1'b0);
    setSprite(11, 0, 16, 3, 1'b1, 1'b1);
    setSprite(12, -3, -5, 4, 1'b1, 1'b1);
    setSprite(13, 100, 100, 4, 1'b0, 1'b1);
    setSprite(14, 1, 1, 6, 1'b1, 1'b1);
    runScan(1'b1, 0, "R5");
    chk(findGot(13) < 0, "R7", "disabled sprite emitted", findGot(13), -1);
    k = findGot(14);
    chk(k >= 0 && gotX[k] == 118 && gotY[k] == 142, "R7", "hidden member carries base X",
        (k >= 0) ? gotX[k] : -999, 118);
    wr(0, 10, 50);
    wr(1, 10, 60);
    runScan(1'b0, 0, "R6");
    k = findGot(12);
    chk(k >= 0 && gotX[k] == 47 && gotY[k] == 71, "R6", "follower shifted X",
        (k >= 0) ? gotX[k] : -999, 47);
    k = findGot(14);
    chk(k >= 0 && gotY[k] == 172, "R6", "tail shifted Y", (k >= 0) ? gotY[k] : -999, 172);
  endtask

  task automatic testBusyWrite();
    int k;
    wrT = 0; wrI = 10; wrD = 0;
    runScan(1'b0, 2, "R10");
    repeat (3) @(negedge clk);
    chk(cpuBusy == 0, "R10", "start while busy ignored", int'(cpuBusy), 0);
    runScan(1'b1, 0, "R10");
    k = findGot(10);
    chk(k >= 0 && gotX[k] == 50, "R10", "write while busy dropped", (k >= 0) ? gotX[k] : -999, 50);
  endtask

  task automatic testSameCycle();
    int k;
    setSprite(511, 300, 255, 8, 1'b1, 1'b0);
    wrT = 2; wrI = 3; wrD = 9;
    shI[3] = 8'd9;
    runScan(1'b1, 1, "R11");
    k = findGot(3);
    chk(k >= 0 && gotImg[k] == 9, "R11", "write with start seen", (k >= 0) ? gotImg[k] : -999, 9);
    k = findGot(511);
    chk(k >= 0 && gotX[k] == -212 && gotY[k] == 255, "R3", "X bit 8 from control byte",
        (k >= 0) ? gotX[k] : -999, -212);
  endtask

  initial begin
    for (int i = 0; i < NSPR; i++) begin
      shX[i] = '0; shY[i] = '0; shI[i] = '0; shC[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAbsolute();
    testChain();
    testBusyWrite();
    testSameCycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule